// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Decoder

This block sits between a host I/O port and the two channels of a disk controller. Five window bases are held here. Each channel has a command window and a control window, and one bus-master window is shared by both channels. Every host access is matched against these windows, and the block raises exactly one target strobe. The strobe carries an offset relative to the window, along with the access size, the write data and the direction. The drive registers and the DMA engine sit behind the strobes and are not part of this block.

Several corrections are applied along the way:
- The primary command offset is shifted right by a programmable amount.
- The primary control offset has a programmable constant added to it.
- The bus-master window is split between the channels at byte 8.
- A write to command offset 6 is snooped to track which drive (first or second) is selected on each channel.

Accesses are gated by an I/O enable bit and a bus-master enable bit, both taken from a config command register. Config writes load the window bases.

Top module: `dual_chan_io_decoder`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes raises `size_err` and no strobe.
- R2: With I/O enable clear, an access raises no strobe and no error flag.
- R3: In the primary command window, `tgt_off` is the relative address shifted right by `pcmd_shift`. In the secondary command window it is the unshifted relative address.
- R4: In the primary control window, `tgt_off` is the relative address plus `pctl_add`. In the secondary control window no value is added.
- R5: With bus-master enable clear, writes to the bus-master window raise no strobe and no flag. Reads still raise a strobe.
- R6: Bus-master relative offsets 0 to 7 strobe `tgt_req[4]` (primary) with the offset unchanged. Offsets of 8 and above strobe `tgt_req[5]` (secondary) with 8 subtracted.
- R7: A write whose command-window offset is 6 sets that channel's `drv_sel` bit to write-data bit 4. `drv_sel[0]` is the primary channel and `drv_sel[1]` the secondary. No other access changes `drv_sel`.
- R8: A command or control access to a channel whose selected drive is absent raises `no_drive` and no strobe; the host returns zero for such a read. `drv_present` bit index is {channel, drive select}.
- R9: `cfg_wr` with `cfg_idx` 0..4 loads the base of, in order: primary command, primary control, secondary command, secondary control, bus-master. The load happens only when `cfg_wdata` is nonzero.
- R10: `cfg_wr` with `cfg_idx` 5 loads I/O enable from data bit 0 and bus-master enable from data bit 2. Other bits are ignored.
- R11: An enabled access of legal size that hits no window raises `dec_err`.
- R12: Results appear on the clock after `acc_valid`. At most one `tgt_req` bit is high. Flags and strobes are low in cycles with no access. `tgt_req` bits are: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 primary bus-master, 5 secondary bus-master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_idx | input | 3 | Config register index: 0..4 bases, 5 command |
| cfg_wdata | input | AW | Config write data |
| pcmd_shift | input | SHW | Right shift for primary command offsets |
| pctl_add | input | ADDW | Constant added to primary control offsets |
| drv_present | input | 4 | Drive attached, index {channel, select} |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | AW | Host I/O address |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | DW | Host write data |
| tgt_req | output | 6 | One-hot target strobe |
| tgt_off | output | AW | Offset within the target |
| tgt_size | output | 3 | Size forwarded to the target |
| tgt_wdata | output | DW | Data forwarded to the target |
| tgt_write | output | 1 | Direction forwarded to the target |
| drv_sel | output | 2 | Selected drive, per channel |
| no_drive | output | 1 | Access to an absent drive |
| size_err | output | 1 | Illegal access size |
| dec_err | output | 1 | Address hit no window |

## Verification
The decoder is driven with addresses that land at different positions inside each of the five windows, and with addresses outside all of them. This shows whether the target choice, the primary shift and the primary add are each confined to the correct window. Bus-master addresses on both sides of byte 8 check the channel split. Access sizes of 0, 3 and the legal values separate size rejection from decode. Writes at command offset 6 with data bit 4 set and clear, each followed by reads, test drive selection and the absent-drive path. Config writes of zero, and command values with single enable bits, test the base load rule and the gating.

// File: rtl/dual_chan_io_decoder.sv
module dual_chan_io_decoder #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SHW       = 2,
  parameter int ADDW      = 4,
  parameter int CMD_BYTES = 16,
  parameter int CTL_BYTES = 4,
  parameter int BM_BYTES  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_idx,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [SHW-1:0]  pcmd_shift,
  input  logic [ADDW-1:0] pctl_add,
  input  logic [3:0]      drv_present,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [AW-1:0]   acc_addr,
  input  logic [2:0]      acc_size,
  input  logic [DW-1:0]   acc_wdata,
  output logic [5:0]      tgt_req,
  output logic [AW-1:0]   tgt_off,
  output logic [2:0]      tgt_size,
  output logic [DW-1:0]   tgt_wdata,
  output logic            tgt_write,
  output logic [1:0]      drv_sel,
  output logic            no_drive,
  output logic            size_err,
  output logic            dec_err
);
  localparam int W1       = AW + 1;
  localparam int BM_SPLIT = 8;
  localparam int SEL_OFF  = 6;
  localparam int NBASE    = 5;
  localparam int CMD_IDX  = 5;

  logic [AW-1:0] base_q [NBASE];
  logic          io_en, bm_en;
  logic [1:0]    sel_q;

  function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] b, input int unsigned n);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < ({1'b0, b} + W1'(n)));
  endfunction

  wire h_pcmd = in_win(acc_addr, base_q[0], CMD_BYTES);
  wire h_pctl = in_win(acc_addr, base_q[1], CTL_BYTES);
  wire h_scmd = in_win(acc_addr, base_q[2], CMD_BYTES);
  wire h_sctl = in_win(acc_addr, base_q[3], CTL_BYTES);
  wire h_bm   = in_win(acc_addr, base_q[4], BM_BYTES);

  wire [AW-1:0] off_pcmd = (acc_addr - base_q[0]) >> pcmd_shift;
  wire [AW-1:0] off_pctl = (acc_addr - base_q[1]) + AW'(pctl_add);
  wire [AW-1:0] off_scmd = acc_addr - base_q[2];
  wire [AW-1:0] off_sctl = acc_addr - base_q[3];
  wire [AW-1:0] rel_bm   = acc_addr - base_q[4];

  wire size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
  wire snoop   = acc_write && acc_wdata[4];

  logic [5:0]    n_req;
  logic [AW-1:0] n_off;
  logic [1:0]    n_sel;
  logic          n_nodrv, n_serr, n_derr;

  always_comb begin
    n_req   = '0;
    n_off   = '0;
    n_sel   = sel_q;
    n_nodrv = 1'b0;
    n_serr  = 1'b0;
    n_derr  = 1'b0;
    if (acc_valid) begin
      if (!size_ok) begin
        n_serr = 1'b1;
      end else if (io_en) begin
        if (h_pcmd) begin
          n_off = off_pcmd;
          if (acc_write && off_pcmd == AW'(SEL_OFF)) n_sel[0] = snoop;
          if (drv_present[{1'b0, n_sel[0]}]) n_req[0] = 1'b1; else n_nodrv = 1'b1;
        end else if (h_pctl) begin
          n_off = off_pctl;
          if (drv_present[{1'b0, sel_q[0]}]) n_req[1] = 1'b1; else n_nodrv = 1'b1;
        end else if (h_scmd) begin
          n_off = off_scmd;
          if (acc_write && off_scmd == AW'(SEL_OFF)) n_sel[1] = snoop;
          if (drv_present[{1'b1, n_sel[1]}]) n_req[2] = 1'b1; else n_nodrv = 1'b1;
        end else if (h_sctl) begin
          n_off = off_sctl;
          if (drv_present[{1'b1, sel_q[1]}]) n_req[3] = 1'b1; else n_nodrv = 1'b1;
        end else if (h_bm) begin
          if (!acc_write || bm_en) begin
            if (rel_bm < AW'(BM_SPLIT)) begin
              n_req[4] = 1'b1;
              n_off    = rel_bm;
            end else begin
              n_req[5] = 1'b1;
              n_off    = rel_bm - AW'(BM_SPLIT);
            end
          end
        end else begin
          n_derr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBASE; i++) base_q[i] <= '0;
      io_en <= 1'b0;
      bm_en <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_idx == 3'(CMD_IDX)) begin
        io_en <= cfg_wdata[0];
        bm_en <= cfg_wdata[2];
      end else if (cfg_idx < 3'(NBASE) && cfg_wdata != '0) begin
        base_q[cfg_idx] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_req   <= '0;
      tgt_off   <= '0;
      tgt_size  <= '0;
      tgt_wdata <= '0;
      tgt_write <= 1'b0;
      sel_q     <= '0;
      no_drive  <= 1'b0;
      size_err  <= 1'b0;
      dec_err   <= 1'b0;
    end else begin
      tgt_req  <= n_req;
      sel_q    <= n_sel;
      no_drive <= n_nodrv;
      size_err <= n_serr;
      dec_err  <= n_derr;
      if (acc_valid) begin
        tgt_off   <= n_off;
        tgt_size  <= acc_size;
        tgt_wdata <= acc_wdata;
        tgt_write <= acc_write;
      end
    end
  end

  assign drv_sel = sel_q;

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_req));
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (tgt_req == '0) && !size_err && !dec_err && !no_drive);
  assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !size_ok) |=> size_err && (tgt_req == '0));
  assert_io_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !io_en) |=> (tgt_req == '0) && !dec_err && !no_drive);
  assert_bm_wr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !bm_en) |=> !tgt_req[4] && !tgt_req[5]);
  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(drv_sel));
  assert_zero_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == 3'd0 && cfg_wdata == '0) |=> $stable(base_q[0]));
endmodule

// File: tb/test_dual_chan_io_decoder.sv
module test_dual_chan_io_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  pcmd_shift = 2'd1;
  logic [3:0]  pctl_add = 4'd2;
  logic [3:0]  drv_present = 4'b0111;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [2:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [5:0]  tgt_req;
  logic [15:0] tgt_off;
  logic [2:0]  tgt_size;
  logic [31:0] tgt_wdata;
  logic        tgt_write;
  logic [1:0]  drv_sel;
  logic        no_drive, size_err, dec_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dual_chan_io_decoder i_dual_chan_io_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .pcmd_shift(pcmd_shift), .pctl_add(pctl_add), .drv_present(drv_present),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .tgt_req(tgt_req), .tgt_off(tgt_off), .tgt_size(tgt_size),
    .tgt_wdata(tgt_wdata), .tgt_write(tgt_write), .drv_sel(drv_sel), .no_drive(no_drive),
    .size_err(size_err), .dec_err(dec_err));

  typedef struct packed {
    logic        w;
    logic [15:0] addr;
    logic [2:0]  size;
    logic [31:0] wd;
    logic [5:0]  req;
    logic [15:0] off;
    logic [2:0]  flg;   // {size_err, dec_err, no_drive}
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h01F4, 3'd1, 32'h0, 6'h01, 16'd2, 3'b000, 4'd3},   // R3 shifted primary command
    '{1'b0, 16'h01F0, 3'd2, 32'h0, 6'h01, 16'd0, 3'b000, 4'd3},   // R3
    '{1'b0, 16'h0174, 3'd1, 32'h0, 6'h04, 16'd4, 3'b000, 4'd3},   // R3 secondary unshifted
    '{1'b0, 16'h03F5, 3'd1, 32'h0, 6'h02, 16'd3, 3'b000, 4'd4},   // R4 primary control plus 2
    '{1'b0, 16'h0376, 3'd1, 32'h0, 6'h08, 16'd2, 3'b000, 4'd4},   // R4 secondary no add
    '{1'b0, 16'hC002, 3'd1, 32'h0, 6'h10, 16'd2, 3'b000, 4'd6},   // R6 low half
    '{1'b0, 16'hC00A, 3'd4, 32'h0, 6'h20, 16'd2, 3'b000, 4'd6},   // R6 high half
    '{1'b1, 16'hC008, 3'd1, 32'h5, 6'h20, 16'd0, 3'b000, 4'd6},   // R6 split boundary
    '{1'b0, 16'h2000, 3'd1, 32'h0, 6'h00, 16'd0, 3'b010, 4'd11},  // R11 no window
    '{1'b0, 16'h01F0, 3'd3, 32'h0, 6'h00, 16'd0, 3'b100, 4'd1},   // R1 size 3
    '{1'b0, 16'h01F0, 3'd0, 32'h0, 6'h00, 16'd0, 3'b100, 4'd1},   // R1 size 0
    '{1'b1, 16'h0176, 3'd1, 32'h10, 6'h00, 16'd0, 3'b001, 4'd7},  // R7 select absent drive
    '{1'b0, 16'h0170, 3'd1, 32'h0, 6'h00, 16'd0, 3'b001, 4'd8},   // R8 command read
    '{1'b0, 16'h0374, 3'd1, 32'h0, 6'h00, 16'd0, 3'b001, 4'd8},   // R8 control read
    '{1'b1, 16'h0176, 3'd1, 32'h0, 6'h04, 16'd6, 3'b000, 4'd7},   // R7 select back
    '{1'b1, 16'h01FC, 3'd1, 32'h10, 6'h01, 16'd6, 3'b000, 4'd7},  // R7 via shifted offset
    '{1'b0, 16'h01F2, 3'd2, 32'h0, 6'h01, 16'd1, 3'b000, 4'd7},   // R7 second drive present
    '{1'b1, 16'h01FC, 3'd1, 32'h0, 6'h01, 16'd6, 3'b000, 4'd7}    // R7
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R12 watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(tgt_req == 0 && !size_err && !dec_err && !no_drive, "R12 reset outputs",
          {tgt_req, size_err, dec_err, no_drive}, 0);
    check(drv_sel == 0, "R7 reset select", drv_sel, 0);

    // R2 I/O disabled: nothing happens, not even a decode error
    access(1'b0, 16'h2000, 3'd1, 0);
    check(tgt_req == 0 && !dec_err && !no_drive, "R2 io off", {tgt_req, dec_err, no_drive}, 0);

    cfg(3'd0, 16'h01F0);
    cfg(3'd1, 16'h03F4);
    cfg(3'd2, 16'h0170);
    cfg(3'd3, 16'h0374);
    cfg(3'd4, 16'hC000);
    cfg(3'd5, 16'h0005);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].w, VEC[i].addr, VEC[i].size, VEC[i].wd);
      check(tgt_req == VEC[i].req && {size_err, dec_err, no_drive} == VEC[i].flg,
            $sformatf("R%0d vec%0d strobe/flags", VEC[i].tag, i),
            {tgt_req, size_err, dec_err, no_drive}, {VEC[i].req, VEC[i].flg});
      if (VEC[i].req != 0)
        check(tgt_off == VEC[i].off && tgt_size == VEC[i].size && tgt_write == VEC[i].w &&
              (!VEC[i].w || tgt_wdata == VEC[i].wd),
              $sformatf("R%0d vec%0d offset/fields", VEC[i].tag, i),
              {tgt_off, tgt_size, tgt_write}, {VEC[i].off, VEC[i].size, VEC[i].w});
    end
    check(drv_sel == 2'b00, "R7 final select", drv_sel, 0);

    // R9 a zero base write is ignored
    cfg(3'd0, 16'h0000);
    access(1'b0, 16'h01F4, 3'd1, 0);
    check(tgt_req == 6'h01 && tgt_off == 16'd2, "R9 zero base ignored", {tgt_req, tgt_off}, {6'h01, 16'd2});
    // R9 nonzero base moves the window
    cfg(3'd2, 16'h0180);
    access(1'b0, 16'h0182, 3'd1, 0);
    check(tgt_req == 6'h04 && tgt_off == 16'd2, "R9 base moved", {tgt_req, tgt_off}, {6'h04, 16'd2});
    access(1'b0, 16'h0170, 3'd1, 0);
    check(dec_err && tgt_req == 0, "R9 old base gone", {tgt_req, dec_err}, 1);

    // R10 bit 2 alone: I/O still off
    cfg(3'd5, 16'h0004);
    access(1'b0, 16'h01F4, 3'd1, 0);
    check(tgt_req == 0 && !dec_err, "R10 io enable is bit 0", {tgt_req, dec_err}, 0);
    // R10 bits 0 and 1: I/O on, bus-master off
    cfg(3'd5, 16'h0003);
    access(1'b1, 16'hC000, 3'd1, 32'h9);
    check(tgt_req == 0 && !dec_err, "R5 bm write dropped", {tgt_req, dec_err}, 0);
    access(1'b0, 16'hC009, 3'd1, 0);
    check(tgt_req == 6'h20 && tgt_off == 16'd1, "R5 bm read proceeds", {tgt_req, tgt_off}, {6'h20, 16'd1});
    access(1'b1, 16'h0182, 3'd1, 32'h7);
    check(tgt_req == 6'h04 && tgt_write, "R10 io on from bit 0", tgt_req, 6'h04);

    // R12 idle cycle after an access
    @(negedge clk);
    check(tgt_req == 0 && !size_err && !dec_err && !no_drive, "R12 idle", tgt_req, 0);

    done = 1;
    summary();
  end
endmodule